// File: doc/BRIEF.md
# Fall-Through Strobe FIFO

This block is a first-in first-out store of 64 four-bit words. It is built as a chain of word stages, not as a RAM with pointers. A word written at the input stage falls toward the output stage on its own. It moves at most one stage per clock, and only into a neighbouring stage that is empty. When a word leaves the output stage, the vacancy it leaves climbs back toward the input in the same way.

The write side uses a level-sampled shift-in strobe and an input-ready flag. The flag drops while the input stage is occupied, and it also stays low while the whole store is full. The read side uses a shift-out strobe, acted on at its rising edge, and an output-ready flag that is high while a valid word sits in the output stage.

An active-low master reset, sampled on the clock edge, empties every stage. It also clears the output word to zero. An output enable switches the data outputs between the output-stage word and high impedance. All logic runs on one clock.

Top module: `ripple_fifo`

## Requirements
- R1: The FIFO holds exactly 64 words of 4 bits each and returns them at the output in the order they were written.
- R2: When in_ready is high and shift_in is sampled high at a clock edge, din is captured into the input stage, and in_ready is low from that edge on.
- R3: While shift_in stays high after a capture, the word is held in the input stage and in_ready stays low. The word moves on one edge after shift_in is sampled low. If the next stage is empty, in_ready returns high on that same edge.
- R4: With 64 words stored, in_ready stays low. A shift_in pulse while full transfers no data, so no 65th word ever appears at the output.
- R5: Unloading a full FIFO frees the output stage. The vacancy climbs one stage per clock, and in_ready rises 63 clock edges after the unloading edge.
- R6: If shift_in is held high while the FIFO is full, the word on din is loaded automatically when the vacancy reaches the input stage. in_ready is then high for exactly one cycle. shift_in must return low before that word moves on.
- R7: A clock edge with mreset_n low empties the FIFO. After that edge in_ready is 1, out_ready is 0 and dout is 4'b0000.
- R8: out_ready is high while a valid word is in the output stage. A rising edge of shift_out, while out_ready is high, removes that word, and out_ready is low for at least the following cycle.
- R9: A word captured into an empty FIFO, with shift_in high for one cycle, makes out_ready rise 64 clock edges after the capturing edge.
- R10: A rising edge of shift_out while out_ready is low is ignored. No word is lost.
- R11: With oe low, dout is 4'bzzzz. With oe high, dout shows the output-stage word.
- R12: Only the rising edge of shift_out acts. Holding shift_out high removes exactly one word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| mreset_n | input | 1 | Master reset, active low, sampled on the clock edge |
| shift_in | input | 1 | Write strobe, level sampled |
| din | input | 4 | Word to write |
| in_ready | output | 1 | High when the input stage is empty and can take a word |
| shift_out | input | 1 | Read strobe; its rising edge unloads the output stage |
| out_ready | output | 1 | High when a valid word sits in the output stage |
| oe | input | 1 | Output enable, active high |
| dout | output | 4 | Output-stage word, or high impedance when oe is low |

## Verification
The assertions assume the following about the inputs:
- The strobes and din are synchronous to clk.
- mreset_n is held low for the first edges, so every stage starts from a known state.
- shift_out returns low between unloads whenever more than one word is to be removed.

The bench drives every input on the falling clock edge. It samples outputs on the falling edge as well. Apart from the deliberate held-strobe cases, its shift_out pulses are one cycle wide. It writes only while its own model holds fewer than 64 words, or when it is deliberately probing the full store.

// File: rtl/ripple_fifo_pkg.sv
package ripple_fifo_pkg;

    // Position of a stage in the chain; selects its reset behaviour
    typedef enum logic [1:0] {
        ROLE_ENTRY  = 2'd0,
        ROLE_MIDDLE = 2'd1,
        ROLE_EXIT   = 2'd2
    } stage_role_e;

    function automatic stage_role_e role_of(input int idx, input int depth);
        if (idx == depth - 1) return ROLE_EXIT;
        if (idx == 0)         return ROLE_ENTRY;
        return ROLE_MIDDLE;
    endfunction

endpackage

// File: rtl/ripple_edge.sv
module ripple_edge (
    input  logic clk,
    input  logic clr,
    input  logic strobe,
    output logic rise
);
    logic strobe_q;

    always_ff @(posedge clk) begin
        if (clr) strobe_q <= 1'b0;
        else     strobe_q <= strobe;
    end

    assign rise = strobe & ~strobe_q;

    // R12: a strobe held high yields no second edge
    p_single_edge_r12: assert property (@(posedge clk) disable iff (clr)
        rise |=> !rise);

endmodule

// File: rtl/ripple_wr_ctrl.sv
module ripple_wr_ctrl (
    input  logic clk,
    input  logic clr,
    input  logic shift_in,
    input  logic entry_valid,
    output logic offer,
    output logic release_ok
);
    // Set once the current high phase of shift_in has delivered its word
    logic used_q;
    logic capture;

    assign capture    = shift_in & ~used_q & ~entry_valid;
    assign offer      = shift_in & ~used_q;
    assign release_ok = ~used_q;

    always_ff @(posedge clk) begin
        if (clr) used_q <= 1'b0;
        else     used_q <= shift_in & (used_q | capture);
    end

    // R2: an accepted strobe fills the entry stage and marks it busy
    p_capture_busy_r2: assert property (@(posedge clk) disable iff (clr)
        shift_in && !used_q && !entry_valid |=> entry_valid && used_q);

    // R3: a low strobe frees the held word on the next edge
    p_release_after_low_r3: assert property (@(posedge clk) disable iff (clr)
        !shift_in |=> !used_q);

endmodule

// File: rtl/ripple_stage.sv
module ripple_stage
    import ripple_fifo_pkg::*;
#(
    parameter int          WIDTH = 4,
    parameter stage_role_e ROLE  = ROLE_MIDDLE
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             up_offer,
    input  logic [WIDTH-1:0] up_data,
    input  logic             down_free,
    input  logic             release_ok,
    output logic             valid_o,
    output logic [WIDTH-1:0] data_o,
    output logic             offer_o
);
    logic             valid_q;
    logic [WIDTH-1:0] data_q;
    logic             load;

    assign load    = up_offer & ~valid_q;
    assign offer_o = valid_q & down_free & release_ok;
    assign valid_o = valid_q;
    assign data_o  = data_q;

    always_ff @(posedge clk) begin
        if (clr)          valid_q <= 1'b0;
        else if (load)    valid_q <= 1'b1;
        else if (offer_o) valid_q <= 1'b0;
    end

    generate
        if (ROLE == ROLE_EXIT) begin : g_clear_data
            always_ff @(posedge clk) begin
                if (clr)       data_q <= '0;
                else if (load) data_q <= up_data;
            end
        end else begin : g_keep_data
            always_ff @(posedge clk) begin
                if (load) data_q <= up_data;
            end
        end
    endgenerate

    // R9: a stage fills only from a neighbour that offered a word
    p_fill_from_neighbour_r9: assert property (@(posedge clk) disable iff (clr)
        $rose(valid_q) |-> $past(up_offer));

    // R3: a word not released stays in place
    p_stage_hold_r3: assert property (@(posedge clk) disable iff (clr)
        valid_q && !release_ok |=> valid_q);

endmodule

// File: rtl/ripple_fifo.sv
module ripple_fifo
    import ripple_fifo_pkg::*;
#(
    parameter int WIDTH = 4,
    parameter int DEPTH = 64
) (
    input  logic             clk,
    input  logic             mreset_n,
    input  logic             shift_in,
    input  logic [WIDTH-1:0] din,
    output logic             in_ready,
    input  logic             shift_out,
    output logic             out_ready,
    input  logic             oe,
    output logic [WIDTH-1:0] dout
);
    localparam int LAST = DEPTH - 1;

    logic             clr;
    logic             so_rise;
    logic             wr_offer;
    logic             wr_release;
    logic [DEPTH-1:0] vld;
    logic [DEPTH:0]   offer_c;
    logic [WIDTH-1:0] dat [DEPTH+1];

    assign clr        = ~mreset_n;
    assign offer_c[0] = wr_offer;
    assign dat[0]     = din;

    ripple_edge u_so_edge (
        .clk    (clk),
        .clr    (clr),
        .strobe (shift_out),
        .rise   (so_rise)
    );

    ripple_wr_ctrl u_wr (
        .clk         (clk),
        .clr         (clr),
        .shift_in    (shift_in),
        .entry_valid (vld[0]),
        .offer       (wr_offer),
        .release_ok  (wr_release)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        logic down_free;
        logic rel;

        if (i == LAST) begin : g_exit
            assign down_free = so_rise;
        end else begin : g_inner
            assign down_free = ~vld[i+1];
        end

        if (i == 0) begin : g_entry_rel
            assign rel = wr_release;
        end else begin : g_free_rel
            assign rel = 1'b1;
        end

        ripple_stage #(
            .WIDTH (WIDTH),
            .ROLE  (role_of(i, DEPTH))
        ) u_stage (
            .clk        (clk),
            .clr        (clr),
            .up_offer   (offer_c[i]),
            .up_data    (dat[i]),
            .down_free  (down_free),
            .release_ok (rel),
            .valid_o    (vld[i]),
            .data_o     (dat[i+1]),
            .offer_o    (offer_c[i+1])
        );
    end

    assign in_ready  = ~vld[0];
    assign out_ready = vld[LAST];
    assign dout      = oe ? dat[DEPTH] : {WIDTH{1'bz}};

    // R4: a full store with no unload keeps the input closed
    p_full_blocks_r4: assert property (@(posedge clk) disable iff (clr)
        ($countones(vld) == DEPTH) && !so_rise |=> !in_ready);

    // R8: the unloading edge leaves the output stage empty for a cycle
    p_unload_drops_ready_r8: assert property (@(posedge clk) disable iff (clr)
        offer_c[DEPTH] |=> !out_ready);

    // R10: without an unload the stored word count never shrinks
    p_no_loss_r10: assert property (@(posedge clk) disable iff (clr)
        !offer_c[DEPTH] |=> $countones(vld) >= $past($countones(vld)));

endmodule

// File: tb/ripple_fifo_bench.sv
module ripple_fifo_bench;
    localparam int W = 4;
    localparam int D = 64;

    logic         clk = 1'b0;
    logic         mreset_n = 1'b0;
    logic         shift_in = 1'b0;
    logic [W-1:0] din = '0;
    logic         in_ready;
    logic         shift_out = 1'b0;
    logic         out_ready;
    logic         oe = 1'b1;
    logic [W-1:0] dout;

    int n_chk = 0;
    int n_bad = 0;
    logic [W-1:0] model [$];

    always #5 clk = ~clk;

    ripple_fifo #(.WIDTH(W), .DEPTH(D)) u_ripple_fifo (
        .clk(clk), .mreset_n(mreset_n), .shift_in(shift_in), .din(din),
        .in_ready(in_ready), .shift_out(shift_out), .out_ready(out_ready),
        .oe(oe), .dout(dout)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (ok !== 1'b1) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    // Expected head word of the model
    function automatic logic [W-1:0] head();
        return model[0];
    endfunction

    task automatic write_word(input logic [W-1:0] d);
        int t = 0;
        while (!in_ready && t < 600) begin tick(); t++; end
        chk(in_ready, "R1 in_ready before write", int'(in_ready), 1);
        din = d;
        shift_in = 1'b1;
        tick();
        chk(in_ready == 1'b0, "R2 busy after capture", int'(in_ready), 0);
        shift_in = 1'b0;
        model.push_back(d);
    endtask

    task automatic read_word();
        int t = 0;
        while (!out_ready && t < 600) begin tick(); t++; end
        chk(out_ready, "R8 out_ready before read", int'(out_ready), 1);
        chk(dout == head(), "R1 order at output", int'(dout), int'(head()));
        shift_out = 1'b1;
        tick();
        chk(out_ready == 1'b0, "R8 out_ready drops after unload", int'(out_ready), 0);
        shift_out = 1'b0;
        void'(model.pop_front());
    endtask

    task automatic drain();
        while (model.size() > 0) read_word();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        summary();
        $finish;
    end

    initial begin
        int cnt;
        void'($urandom(32'd20240611));
        @(negedge clk);
        idle(3);
        // R7: reset state
        chk(in_ready == 1'b1, "R7 in_ready after reset", int'(in_ready), 1);
        chk(out_ready == 1'b0, "R7 out_ready after reset", int'(out_ready), 0);
        chk(dout == 4'h0, "R7 dout after reset", int'(dout), 0);
        mreset_n = 1'b1;
        tick();

        // R9: latency of one word through an empty chain
        din = 4'h5;
        shift_in = 1'b1;
        tick();
        shift_in = 1'b0;
        model.push_back(4'h5);
        repeat (D - 1) @(posedge clk);
        @(negedge clk);
        chk(out_ready == 1'b0, "R9 not yet at output", int'(out_ready), 0);
        tick();
        chk(out_ready == 1'b1, "R9 arrives after DEPTH edges", int'(out_ready), 1);
        chk(dout == 4'h5, "R9 word value", int'(dout), 5);
        // R11: output enable
        oe = 1'b0;
        #1;
        chk(dout === 4'bzzzz, "R11 dout high impedance", int'(dout === 4'bzzzz), 1);
        @(negedge clk);
        oe = 1'b1;
        #1;
        chk(dout == 4'h5, "R11 dout enabled", int'(dout), 5);
        @(negedge clk);
        read_word();

        // R3: held strobe keeps the word in the entry stage
        din = 4'h9;
        shift_in = 1'b1;
        tick();
        for (int k = 0; k < 4; k++) begin
            tick();
            chk(in_ready == 1'b0, "R3 busy while strobe high", int'(in_ready), 0);
        end
        shift_in = 1'b0;
        model.push_back(4'h9);
        tick();
        chk(in_ready == 1'b0, "R3 still held on low-sample edge", int'(in_ready), 0);
        tick();
        chk(in_ready == 1'b1, "R3 released next edge", int'(in_ready), 1);
        read_word();

        // R10: unload strobe while the word is still falling through
        write_word(4'hA);
        shift_out = 1'b1;
        tick();
        shift_out = 1'b0;
        tick();
        chk(out_ready == 1'b0, "R10 word still in flight", int'(out_ready), 0);
        read_word();

        // R12: held shift_out removes one word only
        write_word(4'h1);
        write_word(4'h2);
        idle(150);
        shift_out = 1'b1;
        idle(150);
        shift_out = 1'b0;
        void'(model.pop_front());
        tick();
        chk(out_ready == 1'b1, "R12 second word remains", int'(out_ready), 1);
        chk(dout == 4'h2, "R12 second word value", int'(dout), 2);
        drain();

        // R1 / R4: fill to capacity
        for (int k = 0; k < D; k++) write_word(4'($urandom));
        idle(200);
        chk(in_ready == 1'b0, "R4 full keeps in_ready low", int'(in_ready), 0);
        din = 4'hF;
        shift_in = 1'b1;
        idle(2);
        shift_in = 1'b0;
        idle(10);
        chk(in_ready == 1'b0, "R4 shift_in while full ignored", int'(in_ready), 0);

        // R5: vacancy climbs back
        chk(dout == head(), "R5 head before unload", int'(dout), int'(head()));
        shift_out = 1'b1;
        @(posedge clk);
        @(negedge clk);
        shift_out = 1'b0;
        void'(model.pop_front());
        repeat (D - 2) @(posedge clk);
        @(negedge clk);
        chk(in_ready == 1'b0, "R5 vacancy not yet at entry", int'(in_ready), 0);
        tick();
        chk(in_ready == 1'b1, "R5 vacancy reaches entry", int'(in_ready), 1);
        write_word(4'h7);
        idle(100);

        // R6: strobe held high while full
        din = 4'h3;
        shift_in = 1'b1;
        read_word();
        cnt = 0;
        for (int k = 0; k < 200; k++) begin
            tick();
            if (in_ready) cnt++;
        end
        chk(cnt == 1, "R6 one-cycle in_ready pulse", cnt, 1);
        shift_in = 1'b0;
        model.push_back(4'h3);
        idle(5);
        chk(in_ready == 1'b0, "R6 full again", int'(in_ready), 0);
        chk(model.size() == D, "R1 model holds 64", model.size(), D);
        drain();
        idle(100);
        chk(out_ready == 1'b0, "R4 no extra word after drain", int'(out_ready), 0);

        // R7: reset while full
        for (int k = 0; k < D; k++) write_word(4'($urandom));
        idle(100);
        mreset_n = 1'b0;
        tick();
        mreset_n = 1'b1;
        model.delete();
        chk(in_ready == 1'b1, "R7 in_ready after full reset", int'(in_ready), 1);
        chk(out_ready == 1'b0, "R7 out_ready after full reset", int'(out_ready), 0);
        chk(dout == 4'h0, "R7 dout cleared", int'(dout), 0);

        // Random mix of writes and reads
        for (int k = 0; k < 300; k++) begin
            int op;
            op = int'($urandom % 3);
            if (op < 2 && model.size() < D) write_word(4'($urandom));
            else if (model.size() > 0)       read_word();
            idle(int'($urandom % 3));
        end
        drain();

        summary();
        $finish;
    end
endmodule